// File: doc/BRIEF.md
# Mersenne-Prime Base-Field Arithmetic Unit

This unit does arithmetic modulo the Mersenne prime q = 2^W − 1 on W-bit operands, W being 13 by default. A two-bit operation code picks one of four operations: add, subtract, negate or multiply. The result is registered and appears one clock after the operands. A build-time parameter can remove that register and leave a purely combinational path.

All arithmetic relies on 2^W ≡ 1 (mod q). An addition therefore reduces by adding its carry-out back in at bit 0. That second addition is always performed, even when the carry is 0, so the logic path and its timing are the same for every input. Negation is a bitwise inversion, since q is all ones. Subtraction feeds the inverted subtrahend into the adder. Multiplication uses a carry-save array of W rows. Row k adds the first operand rotated left by k, gated by bit k of the second operand. Carries leaving the top column wrap to column 0 of the next row. A final end-around ripple adder merges the sum and carry vectors.

Zero has two encodings, all zeros and all ones. Both are accepted on input and either may appear on output, so results are meaningful modulo q.

Top module: `mers_alu`

## Requirements
- R1: With op_i = 2'b00 (add), res_o is congruent to a_i + b_i modulo q.
- R2: The carry out of the top bit of the raw sum is always re-added at bit 0. When a_i + b_i ≥ 2^W, res_o equals a_i + b_i − 2^W + 1 exactly.
- R3: With op_i = 2'b01 (subtract), res_o is congruent to a_i − b_i modulo q.
- R4: With op_i = 2'b11 (negate), res_o equals the bitwise NOT of b_i exactly, and a_i has no effect on it.
- R5: With op_i = 2'b10 (multiply), res_o is congruent to a_i · b_i modulo q.
- R6: An operand equal to q (all ones) behaves as zero in every operation.
- R7: With REG_OUT = 1, res_o is updated only on the rising clock edge, one cycle after the operands and op_i are presented. While rst_ni is low, res_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Operation: 00 add, 01 subtract, 10 multiply, 11 negate |
| a_i | input | W | First operand |
| b_i | input | W | Second operand (subtrahend, negation source) |
| res_o | output | W | Result modulo q, either zero encoding allowed |

## Verification
The bench builds the unit with W = 13 and REG_OUT = 1, so q = 8191 and a full 13-row wrapping array sits behind the output register. This puts exact end-around cases within reach, such as 4096 + 4096 and 8191 + 8191. It also covers both zero encodings on each operand, and products whose carry-save vectors wrap many times, alongside several hundred random operands per operation. The registered setting also lets the bench see that the output holds between edges and is cleared in reset.

// File: rtl/mers_pkg.sv
package mers_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_MUL = 2'b10,
    OP_NEG = 2'b11
  } mers_op_e;

  // reference reduction used only by the checkers
  function automatic logic [31:0] mod_q(input logic [31:0] v, input logic [31:0] q);
    return v % q;
  endfunction
endpackage

// File: rtl/mers_add.sv
module mers_add #(
  parameter int W = 13
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] s_o
);
  logic [W:0]   rc;   // ripple carries
  logic [W-1:0] raw;
  logic [W-1:0] hc;   // end-around half-adder carries

  assign rc[0] = 1'b0;
  assign hc[0] = rc[W];  // always re-added, zero or not

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign raw[i]   = x_i[i] ^ y_i[i] ^ rc[i];
    assign rc[i+1]  = (x_i[i] & y_i[i]) | (rc[i] & (x_i[i] ^ y_i[i]));
    assign s_o[i]   = raw[i] ^ hc[i];
    if (i < W - 1) begin : g_hc
      assign hc[i+1] = raw[i] & hc[i];
    end
  end
endmodule

// File: rtl/mers_mul.sv
module mers_mul #(
  parameter int W = 13
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] p_o
);
  localparam int ROWS = W;

  logic [W-1:0]   sv [ROWS+1];
  logic [W-1:0]   cv [ROWS+1];
  logic [2*W-1:0] dbl;

  assign dbl   = {x_i, x_i};
  assign sv[0] = '0;
  assign cv[0] = '0;

  for (genvar k = 0; k < ROWS; k++) begin : g_row
    logic [W-1:0] pp, cin;
    assign pp  = y_i[k] ? dbl[2*W-1-k -: W] : '0;         // x rotated left by k
    assign cin = {cv[k][W-2:0], cv[k][W-1]};              // top carry wraps to bit 0
    assign sv[k+1] = sv[k] ^ pp ^ cin;
    assign cv[k+1] = (sv[k] & pp) | (sv[k] & cin) | (pp & cin);
  end

  mers_add #(.W(W)) u_fin (
    .x_i (sv[ROWS]),
    .y_i ({cv[ROWS][W-2:0], cv[ROWS][W-1]}),
    .s_o (p_o)
  );
endmodule

// File: rtl/mers_alu.sv
module mers_alu
  import mers_pkg::*;
#(
  parameter int W       = 13,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  localparam logic [31:0] Q   = (32'd1 << W) - 32'd1;
  localparam logic [31:0] TWO = 32'd1 << W;

  mers_op_e     op;
  logic [W-1:0] b_sel, sum, prod, nxt;

  assign op    = mers_op_e'(op_i);
  assign b_sel = (op == OP_SUB) ? ~b_i : b_i;

  mers_add #(.W(W)) u_add (.x_i(a_i), .y_i(b_sel), .s_o(sum));
  mers_mul #(.W(W)) u_mul (.x_i(a_i), .y_i(b_i),   .p_o(prod));

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB: nxt = sum;
      OP_MUL:         nxt = prod;
      default:        nxt = ~b_i;
    endcase
  end

  if (REG_OUT) begin : g_reg
    logic live_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        res_o  <= '0;
        live_q <= 1'b0;
      end else begin
        res_o  <= nxt;
        live_q <= 1'b1;
      end
    end

    assert_add_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_q && $past(op_i) == 2'b00) |->
        mod_q(32'(res_o), Q) == mod_q(32'($past(a_i)) + 32'($past(b_i)), Q));

    assert_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_q && $past(op_i) == 2'b00 && (32'($past(a_i)) + 32'($past(b_i)) >= TWO)) |->
        32'(res_o) == 32'($past(a_i)) + 32'($past(b_i)) - TWO + 32'd1);

    assert_sub_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_q && $past(op_i) == 2'b01) |->
        mod_q(32'(res_o), Q) ==
        mod_q(mod_q(32'($past(a_i)), Q) + Q - mod_q(32'($past(b_i)), Q), Q));

    assert_neg_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_q && $past(op_i) == 2'b11) |-> res_o == ~$past(b_i));

    assert_mul_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_q && $past(op_i) == 2'b10) |->
        mod_q(32'(res_o), Q) == mod_q(32'($past(a_i)) * 32'($past(b_i)), Q));

    assert_first_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !live_q |=> live_q);
  end else begin : g_comb
    assign res_o = nxt;
  end
endmodule

// File: tb/tb_mers_alu.sv
module tb_mers_alu;
  localparam int          W = 13;
  localparam logic [31:0] Q = 32'd8191;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [1:0]   op_i = 2'b00;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic [W-1:0] res_o;

  int n_chk = 0;
  int n_bad = 0;

  mers_alu #(.W(W), .REG_OUT(1'b1)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .a_i(a_i), .b_i(b_i), .res_o(res_o)
  );

  always #10 clk_i = ~clk_i;

  function automatic logic [31:0] golden(input logic [1:0] op, input logic [31:0] a,
                                         input logic [31:0] b);
    logic [31:0] am, bm;
    am = a % Q;
    bm = b % Q;
    case (op)
      2'b00:   return (am + bm) % Q;
      2'b01:   return (am + Q - bm) % Q;
      2'b10:   return (am * bm) % Q;
      default: return (Q - bm) % Q;
    endcase
  endfunction

  task automatic note(input string req, input bit ok, input logic [31:0] got,
                      input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  // drive at a falling edge, result captured at the next rising edge, sampled at the following fall
  task automatic run_mod(input string req, input logic [1:0] op, input logic [W-1:0] a,
                         input logic [W-1:0] b);
    logic [31:0] e;
    @(negedge clk_i);
    op_i = op; a_i = a; b_i = b;
    @(negedge clk_i);
    e = golden(op, 32'(a), 32'(b));
    note(req, (32'(res_o) % Q) == e, 32'(res_o), e);
  endtask

  task automatic run_exact(input string req, input logic [1:0] op, input logic [W-1:0] a,
                           input logic [W-1:0] b, input logic [W-1:0] e);
    @(negedge clk_i);
    op_i = op; a_i = a; b_i = b;
    @(negedge clk_i);
    note(req, res_o == e, 32'(res_o), 32'(e));
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    note("R7 reset", res_o == '0, 32'(res_o), 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_add;
    run_mod("R1 add 0+0", 2'b00, 13'd0, 13'd0);
    run_mod("R1 add small", 2'b00, 13'd100, 13'd23);
    run_mod("R1 add 8190+1", 2'b00, 13'd8190, 13'd1);
    run_exact("R2 wrap 4096+4096", 2'b00, 13'd4096, 13'd4096, 13'd1);
    run_exact("R2 wrap 8191+8191", 2'b00, 13'd8191, 13'd8191, 13'd8191);
    run_exact("R2 wrap 8190+2", 2'b00, 13'd8190, 13'd2, 13'd1);
  endtask

  task automatic t_sub;
    run_mod("R3 sub 5-3", 2'b01, 13'd5, 13'd3);
    run_mod("R3 sub 3-5", 2'b01, 13'd3, 13'd5);
    run_mod("R3 sub 0-1", 2'b01, 13'd0, 13'd1);
    run_mod("R3 sub x-x", 2'b01, 13'd4321, 13'd4321);
    run_mod("R3 sub 1-8190", 2'b01, 13'd1, 13'd8190);
  endtask

  task automatic t_neg;
    for (int i = 0; i < 4; i++) begin
      // a_i varies while b_i stays: output must not move
      run_exact("R4 neg a ignored", 2'b11, 13'(i * 2731 + 7), 13'd1234, ~13'd1234);
    end
    run_exact("R4 neg 0", 2'b11, 13'd55, 13'd0, 13'h1fff);
    run_exact("R4 neg 8190", 2'b11, 13'd0, 13'd8190, 13'd1);
  endtask

  task automatic t_mul;
    run_mod("R5 mul 1*1", 2'b10, 13'd1, 13'd1);
    run_mod("R5 mul 8190*8190", 2'b10, 13'd8190, 13'd8190);
    run_mod("R5 mul 4096*2", 2'b10, 13'd4096, 13'd2);
    run_mod("R5 mul 1*7777", 2'b10, 13'd1, 13'd7777);
    run_mod("R5 mul 0*5000", 2'b10, 13'd0, 13'd5000);
    run_mod("R5 mul 1234*5678", 2'b10, 13'd1234, 13'd5678);
  endtask

  task automatic t_zero_q;
    run_mod("R6 q add", 2'b00, 13'd8191, 13'd77);
    run_mod("R6 q sub a", 2'b01, 13'd8191, 13'd77);
    run_mod("R6 q sub b", 2'b01, 13'd77, 13'd8191);
    run_mod("R6 q mul a", 2'b10, 13'd8191, 13'd6000);
    run_mod("R6 q mul b", 2'b10, 13'd6000, 13'd8191);
    run_mod("R6 q neg", 2'b11, 13'd3, 13'd8191);
  endtask

  task automatic t_latency;
    logic [W-1:0] hold;
    run_exact("R7 setup", 2'b00, 13'd10, 13'd20, 13'd30);
    hold = res_o;
    @(negedge clk_i);
    op_i = 2'b00; a_i = 13'd1000; b_i = 13'd2000;
    #5;
    note("R7 holds before edge", res_o == hold, 32'(res_o), 32'(hold));
    @(negedge clk_i);
    note("R7 updates after edge", res_o == 13'd3000, 32'(res_o), 32'd3000);
  endtask

  task automatic t_random;
    for (int i = 0; i < 1200; i++) begin
      logic [1:0] op;
      op = 2'(i % 4);
      case (op)
        2'b00: run_mod("R1 random", op, 13'($urandom), 13'($urandom));
        2'b01: run_mod("R3 random", op, 13'($urandom), 13'($urandom));
        2'b10: run_mod("R5 random", op, 13'($urandom), 13'($urandom));
        default: begin
          logic [W-1:0] bb;
          bb = 13'($urandom);
          run_exact("R4 random", op, 13'($urandom), bb, ~bb);
        end
      endcase
    end
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_neg();
    t_mul();
    t_zero_q();
    t_latency();
    t_random();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule